// File: doc/BRIEF.md
# Multi-Channel Capture/Compare Timer with PWM

This block is a timer peripheral built around one 16-bit up-counter that all of its channels share as a timebase. The counter advances on a count strobe taken from one of four sources: every clock, one clock in four, one clock in twelve, or each rising edge of an external event input. Each channel owns a 16-bit capture/compare register, a configuration word and one output pin. It can be switched off or run in one of five modes: input-edge capture, internal software timer, toggle-on-match output, square-wave frequency output, or edge-aligned PWM at 8, 9, 10, 11 or 16 bits of resolution.

Software reaches the block through a single-cycle register port: a write strobe with address and data, and a combinational read-data bus. Events are recorded in sticky flags that software clears by writing ones. The channel count and the two clock divisors are parameters. The address map has room for up to six channels.

Top module: `cc_array`

## Requirements
- R1: Register map (4-bit address): 0 = control (bit 0 run, bits 2:1 clock source); 1 = counter value (read/write); 2 = flags (bits NCH-1:0 channel events, bit 15 overflow); 4+2k = channel k configuration (bits 2:0 mode, bit 3 capture on rising edge, bit 4 capture on falling edge, bits 7:5 PWM resolution); 5+2k = channel k capture/compare register. Unused bits read 0.
- R2: After reset the counter, control, flags, all channel registers and all channel pins read 0.
- R3: With run set the counter adds one per count strobe. Source 0 strobes every clock, source 1 every 4th clock, source 2 every 12th clock, and source 3 once per rising edge of ext_evt. The divided sources restart their phase when run is set. With run clear the counter holds, and a write to address 1 loads it.
- R4: The overflow flag (bit 15) is set when a count strobe takes the counter from 0xFFFF to 0x0000.
- R5: Mode 1 (capture) copies the counter into the channel register and sets the channel flag on an enabled edge of ch_in. Bit 3 enables rising edges and bit 4 falling edges; with both set, either edge captures. An edge that is not enabled changes nothing.
- R6: Mode 2 (software timer) sets the channel flag when a count strobe occurs while the counter equals the channel register, and the pin stays 0.
- R7: Mode 3 (toggle output) inverts the pin and sets the flag on each such 16-bit match.
- R8: Mode 4 (frequency output) compares the counter's low byte with the register's low byte. On a match under a strobe the pin inverts, the flag sets, and the register's low byte grows by its high byte (modulo 256).
- R9: Mode 5 (PWM) drives the pin high while the low N counter bits are below the low N bits of the active compare value. N is 8, 9, 10, 11 or 16 for resolution codes 0 to 4. The pin follows the counter with one clock of delay.
- R10: In PWM mode the active compare value takes the channel register only when a count strobe occurs with the low N counter bits all ones. A register write at any other time does not change the pin.
- R11: Flags stay set until a write to address 2 with a 1 in that bit position. Writing 0 leaves a flag unchanged, and a new event in the same cycle wins over the clear. Writing a channel's configuration forces its pin to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| ext_evt | input | 1 | External count event |
| ch_in | input | NCH | Per-channel capture input |
| ch_out | output | NCH | Per-channel output pin |

## Verification
A register write takes effect at the clock edge where it is strobed, and reads are combinational. Counter steps, flags, toggle-mode pins and captured values therefore change at the edge of the qualifying strobe. A capture lands two edges after ch_in changes, because the input passes through two flops for edge detection. A PWM pin settles one edge after the counter value it reflects. Each scenario drives inputs on the falling edge and lets the counter run for an exact number of edges between a start write and a stop write. The bench then reads the results with the counter halted, waiting one extra edge before it samples any PWM or toggle pin. Expected counts follow directly from the edge count: D for source 0, floor(D/4) for source 1 and floor(D/12) for source 2.

// File: rtl/cc_array_pkg.sv
package cc_array_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd2;
    localparam int                A_CH_BASE = 4;
    localparam int                OVF_BIT   = 15;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_CAPT = 3'd1,
        MODE_SWT  = 3'd2,
        MODE_HSO  = 3'd3,
        MODE_FREQ = 3'd4,
        MODE_PWM  = 3'd5
    } chan_mode_e;

    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_DIV_A = 2'd1,
        SRC_DIV_B = 2'd2,
        SRC_EXT   = 2'd3
    } clk_src_e;

    // 8-bit channel configuration word
    typedef struct packed {
        logic [2:0] res;
        logic       fall_en;
        logic       rise_en;
        chan_mode_e mode;
    } chan_cfg_t;

    // low-bit mask of the PWM period for a resolution code
    function automatic logic [CNT_W-1:0] pwm_mask(input logic [2:0] res);
        case (res)
            3'd0:    return 16'h00FF;
            3'd1:    return 16'h01FF;
            3'd2:    return 16'h03FF;
            3'd3:    return 16'h07FF;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/cc_prescale.sv
module cc_prescale
    import cc_array_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     ext_evt,
    output logic     tick
);

    localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int DW   = $clog2(DMAX + 1);

    logic [DW-1:0] div_q;
    logic [DW-1:0] lim;
    logic          ext_q, ext_p;

    always_comb begin
        lim = (src == SRC_DIV_A) ? DW'(DIV_A - 1) : DW'(DIV_B - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            ext_q <= 1'b0;
            ext_p <= 1'b0;
        end else begin
            ext_q <= ext_evt;
            ext_p <= ext_q;
            if (!run || div_q >= lim) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    always_comb begin
        case (src)
            SRC_FULL:             tick = run;
            SRC_DIV_A, SRC_DIV_B: tick = run && (div_q == lim);
            SRC_EXT:              tick = run && ext_q && !ext_p;
            default:              tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_timebase.sv
module cc_timebase
    import cc_array_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap = tick && !load && (cnt == '1);

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_array_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  chan_cfg_t        cfg_in,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_in,
    input  logic             pin_in,
    output chan_cfg_t        cfg,
    output logic [CNT_W-1:0] ccr,
    output logic             pin_out,
    output logic             event_o
);

    logic             in_q, in_p;
    logic             rise, fall;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] mask;
    logic             hit_full, hit_low, roll, capt;

    always_comb begin
        rise     = in_q && !in_p;
        fall     = !in_q && in_p;
        mask     = pwm_mask(cfg.res);
        hit_full = tick && (cnt == ccr);
        hit_low  = tick && (cnt[7:0] == ccr[7:0]);
        roll     = tick && ((cnt & mask) == mask);
        capt     = (cfg.mode == MODE_CAPT) &&
                   ((rise && cfg.rise_en) || (fall && cfg.fall_en));
        case (cfg.mode)
            MODE_CAPT:          event_o = capt;
            MODE_SWT, MODE_HSO: event_o = hit_full;
            MODE_FREQ:          event_o = hit_low;
            default:            event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q    <= 1'b0;
            in_p    <= 1'b0;
            cfg     <= '{res: 3'd0, fall_en: 1'b0, rise_en: 1'b0, mode: MODE_OFF};
            ccr     <= '0;
            act_q   <= '0;
            pin_out <= 1'b0;
        end else begin
            in_q <= pin_in;
            in_p <= in_q;

            if (cfg_we) begin
                cfg <= cfg_in;
            end

            if (reg_we) begin
                ccr <= reg_in;
            end else if (capt) begin
                ccr <= cnt;
            end else if (cfg.mode == MODE_FREQ && hit_low) begin
                ccr[7:0] <= ccr[7:0] + ccr[15:8];
            end

            if (cfg.mode == MODE_PWM && roll) begin
                act_q <= ccr;
            end

            if (cfg_we) begin
                pin_out <= 1'b0;
            end else begin
                case (cfg.mode)
                    MODE_HSO, MODE_FREQ: if (event_o) pin_out <= !pin_out;
                    MODE_PWM:            pin_out <= (cnt & mask) < (act_q & mask);
                    default:             pin_out <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cc_array.sv
module cc_array
    import cc_array_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int DIV_A = 4,
    parameter int DIV_B = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ext_evt,
    input  logic [NCH-1:0]    ch_in,
    output logic [NCH-1:0]    ch_out
);

    localparam int PAD_W = OVF_BIT - NCH;

    logic             run_q;
    clk_src_e         src_q;
    logic             ovf_flag;
    logic [NCH-1:0]   ch_flag;
    logic             tick, wrap;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ctrl, wr_count, wr_flags;
    chan_cfg_t        cfg_wr;
    chan_cfg_t        cfg_q [NCH];
    logic [CNT_W-1:0] ccr_q [NCH];
    logic [NCH-1:0]   ev_v;

    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL);
        wr_count = wr_en && (addr == A_COUNT);
        wr_flags = wr_en && (addr == A_FLAGS);
        cfg_wr   = '{res: wr_data[7:5], fall_en: wr_data[4], rise_en: wr_data[3],
                     mode: chan_mode_e'(wr_data[2:0])};
    end

    cc_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .src     (src_q),
        .ext_evt (ext_evt),
        .tick    (tick)
    );

    cc_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_count),
        .load_val (wr_data),
        .cnt      (cnt_q),
        .wrap     (wrap)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        cc_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt     (cnt_q),
            .cfg_we  (wr_en && (addr == ADDR_W'(A_CH_BASE + 2 * k))),
            .cfg_in  (cfg_wr),
            .reg_we  (wr_en && (addr == ADDR_W'(A_CH_BASE + 2 * k + 1))),
            .reg_in  (wr_data),
            .pin_in  (ch_in[k]),
            .cfg     (cfg_q[k]),
            .ccr     (ccr_q[k]),
            .pin_out (ch_out[k]),
            .event_o (ev_v[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            src_q    <= SRC_FULL;
            ovf_flag <= 1'b0;
            ch_flag  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= wr_data[0];
                src_q <= clk_src_e'(wr_data[2:1]);
            end
            ovf_flag <= wrap || (ovf_flag && !(wr_flags && wr_data[OVF_BIT]));
            ch_flag  <= ev_v | (ch_flag & ~(wr_flags ? wr_data[NCH-1:0] : '0));
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL:  rd_data = {13'd0, src_q, run_q};
            A_COUNT: rd_data = cnt_q;
            A_FLAGS: rd_data = {ovf_flag, {PAD_W{1'b0}}, ch_flag};
            default: rd_data = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(A_CH_BASE + 2 * i)) begin
                rd_data = {8'd0, cfg_q[i]};
            end
            if (addr == ADDR_W'(A_CH_BASE + 2 * i + 1)) begin
                rd_data = ccr_q[i];
            end
        end
    end

endmodule

// File: rtl/cc_array_chk.sv
module cc_array_chk
    import cc_array_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf_flag,
    input logic [NCH:0]     flags,
    input logic             flag_wr,
    input chan_cfg_t        cfg [NCH],
    input logic [NCH-1:0]   pins
);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> (cnt == $past(cnt)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (cnt == $past(cnt) + 16'd1));

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt == 16'hFFFF) |=> ovf_flag);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> (($past(flags) & ~flags) == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        // R6
        swt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].mode == MODE_SWT && $past(cfg[g].mode == MODE_SWT)) |-> !pins[g]);
    end

endmodule

bind cc_array cc_array_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_count),
    .cnt      (cnt_q),
    .ovf_flag (ovf_flag),
    .flags    ({ovf_flag, ch_flag}),
    .flag_wr  (wr_flags),
    .cfg      (cfg_q),
    .pins     (ch_out)
);

// File: tb/cc_array_test.sv
module cc_array_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ext_evt = 1'b0;
    logic [2:0]  ch_in = '0;
    logic [2:0]  ch_out;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cc_array uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ext_evt (ext_evt),
        .ch_in   (ch_in),
        .ch_out  (ch_out)
    );

    localparam logic [3:0] CTRL = 4'd0, CNT = 4'd1, FLG = 4'd2;

    function automatic logic [3:0] cfg_a(input int ch);
        return 4'(4 + 2 * ch);
    endfunction

    function automatic logic [3:0] reg_a(input int ch);
        return 4'(5 + 2 * ch);
    endfunction

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: addr %0d got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_pin(input int ch, input logic exp, input string tag);
        n_vec++;
        if (ch_out[ch] !== exp) begin
            n_bad++;
            $display("FAIL %s: ch_out[%0d] got %b expected %b", tag, ch, ch_out[ch], exp);
        end
    endtask

    // run the counter for exactly d edges (d >= 1) from source src
    task automatic run_for(input logic [1:0] src, input int d);
        wr(CTRL, {13'd0, src, 1'b1});
        repeat (d - 1) @(negedge clk);
        wr(CTRL, {13'd0, src, 1'b0});
    endtask

    task automatic t_reset;
        chk_rd(CTRL, 16'h0000, "R2");
        chk_rd(CNT, 16'h0000, "R2");
        chk_rd(FLG, 16'h0000, "R2");
        chk_rd(cfg_a(1), 16'h0000, "R2");
        chk_rd(reg_a(2), 16'h0000, "R2");
        n_vec++;
        if (ch_out !== 3'b000) begin
            n_bad++;
            $display("FAIL R2: ch_out got %b expected 000", ch_out);
        end
    endtask

    task automatic t_prescale;
        wr(CNT, 16'd0); run_for(2'd0, 40);
        chk_rd(CNT, 16'd40, "R3 full rate");
        wr(CNT, 16'd0); run_for(2'd1, 40);
        chk_rd(CNT, 16'd10, "R3 div4");
        wr(CNT, 16'd0); run_for(2'd2, 40);
        chk_rd(CNT, 16'd3, "R3 div12");
        chk_rd(CTRL, 16'h0004, "R1 control readback");
        repeat (10) @(negedge clk);
        chk_rd(CNT, 16'd3, "R3 halted");
        wr(CNT, 16'd0);
        wr(CTRL, 16'h0007);
        for (int i = 0; i < 5; i++) begin
            ext_evt = 1'b1; repeat (2) @(negedge clk);
            ext_evt = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        wr(CTRL, 16'h0006);
        chk_rd(CNT, 16'd5, "R3 external events");
    endtask

    task automatic t_overflow;
        wr(CNT, 16'hFFFE);
        run_for(2'd0, 2);
        chk_rd(CNT, 16'h0000, "R4 wrap");
        chk_rd(FLG, 16'h8000, "R4 flag set");
        wr(FLG, 16'h0000);
        chk_rd(FLG, 16'h8000, "R11 write zero ignored");
        wr(FLG, 16'h8000);
        chk_rd(FLG, 16'h0000, "R11 write one clears");
    endtask

    task automatic t_capture;
        wr(cfg_a(0), 16'h0009);            // capture, rising only
        wr(CNT, 16'h1234);
        ch_in[0] = 1'b1; repeat (3) @(negedge clk);
        chk_rd(reg_a(0), 16'h1234, "R5 rising capture");
        chk_rd(FLG, 16'h0001, "R5 capture flag");
        wr(FLG, 16'hFFFF);
        wr(CNT, 16'h2222);
        ch_in[0] = 1'b0; repeat (3) @(negedge clk);
        chk_rd(reg_a(0), 16'h1234, "R5 falling edge ignored");
        chk_rd(FLG, 16'h0000, "R5 no flag on disabled edge");
        wr(cfg_a(0), 16'h0019);            // both edges
        wr(CNT, 16'h3333);
        ch_in[0] = 1'b1; repeat (3) @(negedge clk);
        chk_rd(reg_a(0), 16'h3333, "R5 any edge rising");
        wr(CNT, 16'h4444);
        ch_in[0] = 1'b0; repeat (3) @(negedge clk);
        chk_rd(reg_a(0), 16'h4444, "R5 any edge falling");
        wr(cfg_a(0), 16'h0000);
        wr(FLG, 16'hFFFF);
    endtask

    task automatic t_swtimer;
        wr(reg_a(1), 16'd5);
        wr(cfg_a(1), 16'h0002);
        wr(CNT, 16'd0);
        run_for(2'd0, 10);
        chk_rd(FLG, 16'h0002, "R6 match flag");
        chk_rd(reg_a(1), 16'd5, "R6 register kept");
        chk_pin(1, 1'b0, "R6 pin quiet");
        wr(cfg_a(1), 16'h0000);
        wr(FLG, 16'hFFFF);
    endtask

    task automatic t_toggle;
        wr(reg_a(2), 16'd3);
        wr(cfg_a(2), 16'h0003);
        wr(CNT, 16'd0);
        run_for(2'd0, 10);
        @(negedge clk);
        chk_pin(2, 1'b1, "R7 first toggle");
        chk_rd(FLG, 16'h0004, "R7 match flag");
        wr(CNT, 16'd0);
        run_for(2'd0, 10);
        @(negedge clk);
        chk_pin(2, 1'b0, "R7 second toggle");
        wr(cfg_a(2), 16'h0000);
        wr(FLG, 16'hFFFF);
    endtask

    task automatic t_freq;
        wr(reg_a(0), 16'h0402);
        wr(cfg_a(0), 16'h0004);
        wr(CNT, 16'd0);
        run_for(2'd0, 4);
        @(negedge clk);
        chk_pin(0, 1'b1, "R8 first half period");
        chk_rd(reg_a(0), 16'h0406, "R8 match point advanced");
        run_for(2'd0, 8);
        @(negedge clk);
        chk_pin(0, 1'b1, "R8 two more toggles");
        chk_rd(reg_a(0), 16'h040E, "R8 match point advanced twice");
        wr(cfg_a(0), 16'h0000);
        wr(FLG, 16'hFFFF);
    endtask

    task automatic pwm_at(input logic [15:0] c, input logic exp, input string tag);
        wr(CNT, c);
        @(negedge clk);
        chk_pin(1, exp, tag);
    endtask

    task automatic t_pwm;
        wr(cfg_a(1), 16'h0005);            // 8-bit PWM
        wr(reg_a(1), 16'h0040);
        pwm_at(16'h0010, 1'b0, "R10 no load before rollover");
        wr(CNT, 16'h00FF); run_for(2'd0, 1); @(negedge clk);
        chk_pin(1, 1'b1, "R9 8-bit after rollover");
        pwm_at(16'h003F, 1'b1, "R9 8-bit below compare");
        pwm_at(16'h0040, 1'b0, "R9 8-bit at compare");
        pwm_at(16'h1FF0, 1'b0, "R9 8-bit uses low bits");
        wr(reg_a(1), 16'h0080);
        pwm_at(16'h0050, 1'b0, "R10 held old compare");
        wr(CNT, 16'h00FF); run_for(2'd0, 1);
        pwm_at(16'h0050, 1'b1, "R10 new compare after rollover");
        wr(cfg_a(1), 16'h0045);            // 10-bit PWM
        wr(reg_a(1), 16'h0300);
        wr(CNT, 16'h03FF); run_for(2'd0, 1);
        pwm_at(16'h02FF, 1'b1, "R9 10-bit below");
        pwm_at(16'h0300, 1'b0, "R9 10-bit at compare");
        pwm_at(16'h04FF, 1'b1, "R9 10-bit wraps at 1024");
        wr(cfg_a(1), 16'h0085);            // 16-bit PWM
        wr(reg_a(1), 16'h8000);
        wr(CNT, 16'hFFFF); run_for(2'd0, 1);
        pwm_at(16'h7FFF, 1'b1, "R9 16-bit below");
        pwm_at(16'h8000, 1'b0, "R9 16-bit at compare");
        wr(cfg_a(1), 16'h0000);
        @(negedge clk);
        chk_pin(1, 1'b0, "R11 config write clears pin");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_overflow();
        t_capture();
        t_swtimer();
        t_toggle();
        t_freq();
        t_pwm();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule